// File: doc/BRIEF.md
# MAC Address Table Command Engine

This block keeps a small forwarding address table and lets software drive it through four 32-bit registers. Three data words hold an entry image: MAC address, port mask, status code and VLAN ID. A function word holds a command code, an optional port filter and a busy bit. Software fills the data words and then writes the function word with busy set. The engine walks the table one slot per clock, clears busy when it is done, and writes results back into the data words when the command returns an entry.

There are four commands. Load adds or refreshes an entry. Purge removes an entry. Flush empties the table. Next steps through the valid entries in slot order. A status code of zero marks an empty slot. Entries match on MAC address together with VLAN ID.

Top module: `mac_table_engine`

## Requirements
- R1: After reset, all four registers read zero and the table holds no valid entry.
- R2: Data word 0 holds MAC bits 31:0. Word 1 holds MAC bits 47:32 in 15:0 and the 7-bit port mask in 22:16. Word 2 holds the status code in 3:0 and the VLAN ID in 23:12. All other bits read zero.
- R3: The function word has these fields:
  - command code in bits 3:0 (1 flush, 2 load, 3 purge, 6 next)
  - port number in bits 11:8
  - full flag in bit 12, read-only
  - port-enable in bit 13
  - busy in bit 31
  A write with bit 31 set starts the command, and bit 31 reads one until the command ends.
- R4: Load writes the data image into the lowest-numbered empty slot. If a valid entry already has the same MAC and VLAN, load overwrites that entry in place instead.
- R5: A load that finds neither a match nor an empty slot sets the full flag and leaves the table unchanged. Every command start clears the full flag.
- R6: Purge empties the valid entry whose MAC and VLAN match the data image. If no entry matches, the table is unchanged.
- R7: Flush empties every slot and holds busy for exactly DEPTH cycles.
- R8: Next writes a valid entry back into the data words, with its full image.
  - If the key status is zero, it returns the first valid entry in slot order.
  - Otherwise it returns the first valid entry after the slot that matches the key's MAC and VLAN.
  - If there is no such entry, all three data words become zero.
- R9: When port-enable is set, next skips entries whose port mask lacks the selected port. A port number of 7 or above matches nothing.
- R10: Writes to any register while busy is one are ignored.
- R11: A command examines one slot per cycle and never holds busy for more than DEPTH cycles. A load that matches slot 0 finishes after one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 to 2 are the data words, 3 is the function word |
| wdata | input | 32 | Write data |
| rd_addr | input | 2 | Read select, same map as wr_addr |
| rdata | output | 32 | Read data for rd_addr, combinational |

## Verification
The bench builds the engine with DEPTH set to 4. At that depth, five loads are enough to fill the table and drive the full-flag path. A purge then opens a gap and exposes the lowest-free-slot rule. With four slots, a flush is short enough that two register writes can land inside its busy window. The small depth also makes the exact flush latency and the one-cycle in-place load directly countable.

// File: rtl/mac_table_engine.sv
module mac_table_engine #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wdata,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rdata
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NPORT = 7;
  localparam logic [3:0] OP_FLUSH = 4'd1;
  localparam logic [3:0] OP_LOAD  = 4'd2;
  localparam logic [3:0] OP_PURGE = 4'd3;
  localparam logic [3:0] OP_NEXT  = 4'd6;

  logic [47:0] k_mac;
  logic [6:0]  k_pm;
  logic [3:0]  k_st;
  logic [11:0] k_vid;
  logic [3:0]  cmd, port;
  logic        port_en, full, busy;
  logic [IW-1:0] idx, free_idx;
  logic        have_free, passed;

  logic [47:0] t_mac [DEPTH];
  logic [6:0]  t_pm  [DEPTH];
  logic [3:0]  t_st  [DEPTH];
  logic [11:0] t_vid [DEPTH];
  logic [DEPTH-1:0] used_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_used
    assign used_vec[g] = (t_st[g] != 4'd0);
  end

  wire       last      = (idx == IW'(DEPTH - 1));
  wire       slot_used = (t_st[idx] != 4'd0);
  wire       key_hit   = slot_used && (t_mac[idx] == k_mac) && (t_vid[idx] == k_vid);
  wire [7:0] pm_ext    = {1'b0, t_pm[idx]};
  wire       port_ok   = !port_en || ((port < 4'(NPORT)) && pm_ext[port[2:0]]);
  wire       fw_hit    = passed && slot_used && port_ok;
  wire       start     = wr_en && (wr_addr == 2'd3) && wdata[31] && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k_mac <= '0; k_pm <= '0; k_st <= '0; k_vid <= '0;
      cmd <= '0; port <= '0; port_en <= 1'b0; full <= 1'b0; busy <= 1'b0;
      idx <= '0; free_idx <= '0; have_free <= 1'b0; passed <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        t_mac[i] <= '0; t_pm[i] <= '0; t_st[i] <= '0; t_vid[i] <= '0;
      end
    end else if (!busy) begin
      if (wr_en) begin
        case (wr_addr)
          2'd0: k_mac[31:0] <= wdata;
          2'd1: begin
            k_mac[47:32] <= wdata[15:0];
            k_pm <= wdata[22:16];
          end
          2'd2: begin
            k_st  <= wdata[3:0];
            k_vid <= wdata[23:12];
          end
          default: begin
            cmd     <= wdata[3:0];
            port    <= wdata[11:8];
            port_en <= wdata[13];
            if (start) begin
              busy      <= 1'b1;
              full      <= 1'b0;
              idx       <= '0;
              have_free <= 1'b0;
              passed    <= (k_st == 4'd0);
            end
          end
        endcase
      end
    end else begin
      idx <= idx + 1'b1;
      case (cmd)
        OP_FLUSH: begin
          t_st[idx] <= 4'd0;
          if (last) busy <= 1'b0;
        end
        OP_LOAD: begin
          if (key_hit) begin
            t_mac[idx] <= k_mac; t_pm[idx] <= k_pm; t_st[idx] <= k_st; t_vid[idx] <= k_vid;
            busy <= 1'b0;
          end else begin
            if (!slot_used && !have_free) begin
              have_free <= 1'b1;
              free_idx  <= idx;
            end
            if (last) begin
              busy <= 1'b0;
              if (have_free) begin
                t_mac[free_idx] <= k_mac; t_pm[free_idx] <= k_pm;
                t_st[free_idx]  <= k_st;  t_vid[free_idx] <= k_vid;
              end else if (!slot_used) begin
                t_mac[idx] <= k_mac; t_pm[idx] <= k_pm; t_st[idx] <= k_st; t_vid[idx] <= k_vid;
              end else begin
                full <= 1'b1;
              end
            end
          end
        end
        OP_PURGE: begin
          if (key_hit) begin
            t_st[idx] <= 4'd0;
            busy <= 1'b0;
          end else if (last) begin
            busy <= 1'b0;
          end
        end
        OP_NEXT: begin
          if (fw_hit) begin
            k_mac <= t_mac[idx]; k_pm <= t_pm[idx]; k_st <= t_st[idx]; k_vid <= t_vid[idx];
            busy <= 1'b0;
          end else begin
            if (!passed && key_hit) passed <= 1'b1;
            if (last) begin
              k_mac <= '0; k_pm <= '0; k_st <= '0; k_vid <= '0;
              busy <= 1'b0;
            end
          end
        end
        default: busy <= 1'b0;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rdata = k_mac[31:0];
      2'd1:    rdata = {9'd0, k_pm, k_mac[47:32]};
      2'd2:    rdata = {8'd0, k_vid, 8'd0, k_st};
      default: rdata = {busy, 17'd0, port_en, full, port, 4'd0, cmd};
    endcase
  end
endmodule

// File: rtl/mac_table_engine_chk.sv
module mac_table_engine_chk #(
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             full,
  input logic [3:0]       cmd,
  input logic             port_en,
  input logic [3:0]       port,
  input logic [70:0]      key_img,
  input logic [DEPTH-1:0] used_vec
);
  int unsigned busy_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_cnt <= 0;
    else busy_cnt <= busy_cnt + 1;
  end

  wire [7:0] key_pm = {1'b0, key_img[54:48]};
  wire       key_empty = (key_img[58:55] == 4'd0);

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) start |=> busy); // R3
  AST_BUSY_FREEZES_DATA: assert property (@(posedge clk) disable iff (!rst_n) (busy && cmd != 4'd6) |=> $stable(key_img)); // R10
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) ($fell(busy) && cmd == 4'd1) |-> (used_vec == '0)); // R7
  AST_FULL_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n) $rose(full) |-> ($past(busy) && $past(cmd) == 4'd2)); // R5
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (busy_cnt < DEPTH)); // R11
  AST_FILTER_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && cmd == 4'd6 && port_en) |-> (key_empty || (port < 4'd7 && key_pm[port[2:0]]))); // R9
endmodule

bind mac_table_engine mac_table_engine_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .full(full), .cmd(cmd),
  .port_en(port_en), .port(port), .key_img({k_vid, k_st, k_pm, k_mac}), .used_vec(used_vec)
);

// File: tb/mac_table_engine_test.sv
module mac_table_engine_test;
  localparam int DEPTH = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0] rd_addr = '0;
  logic [31:0] rdata;
  int checks = 0;
  int fails = 0;
  logic [47:0] got_mac [8];
  int got_n;

  mac_table_engine #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wdata(wdata), .rd_addr(rd_addr), .rdata(rdata)
  );

  always #5 clk = ~clk;

  localparam logic [47:0] MA = 48'h0011_2233_4455;
  localparam logic [47:0] MB = 48'h0A0B_0C0D_0E0F;
  localparam logic [47:0] MD = 48'hFFEE_DDCC_BBAA;
  localparam logic [47:0] ME = 48'h1234_5678_9ABC;
  localparam logic [47:0] MF = 48'h5555_6666_7777;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rdata;
  endtask

  task automatic put(input logic [47:0] mac, input logic [6:0] pm, input logic [3:0] st, input logic [11:0] vid);
    wr(2'd0, mac[31:0]);
    wr(2'd1, {9'd0, pm, mac[47:32]});
    wr(2'd2, {8'd0, vid, 8'd0, st});
  endtask

  task automatic run(input logic [3:0] op, input logic pen, input logic [3:0] prt, output int cyc);
    logic [31:0] v;
    wr(2'd3, {1'b1, 17'd0, pen, 1'b0, prt, 4'd0, op});
    cyc = 0;
    rd(2'd3, v);
    while (v[31] && cyc < 50) begin
      cyc++;
      @(negedge clk);
      rd(2'd3, v);
    end
  endtask

  task automatic walk(input logic pen, input logic [3:0] prt);
    logic [31:0] w0, w1, w2;
    int c;
    put('0, '0, '0, '0);
    got_n = 0;
    for (int k = 0; k < 8; k++) begin
      run(4'd6, pen, prt, c);
      rd(2'd2, w2);
      if (w2[3:0] == 4'd0) break;
      rd(2'd0, w0);
      rd(2'd1, w1);
      got_mac[got_n] = {w1[15:0], w0};
      got_n++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reset register", 64'(v), 64'd0);
    end
  endtask

  task automatic t_layout;
    logic [31:0] v;
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); check("R2 word1 mask", 64'(v), 64'h007F_FFFF);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); check("R2 word2 mask", 64'(v), 64'h00FF_F00F);
    wr(2'd3, 32'h0000_3F06); rd(2'd3, v); check("R3 function fields", 64'(v), 64'h0000_2F06);
    wr(2'd3, 32'h0);
  endtask

  task automatic t_empty_next;
    logic [31:0] v;
    walk(1'b0, 4'd0);
    check("R1 empty table walk", 64'(got_n), 64'd0);
    rd(2'd2, v); check("R8 miss gives zero word2", 64'(v), 64'd0);
    rd(2'd0, v); check("R8 miss gives zero word0", 64'(v), 64'd0);
  endtask

  task automatic t_load;
    logic [31:0] v;
    int c;
    put(MA, 7'h03, 4'hF, 12'h005); run(4'd2, 1'b0, 4'd0, c);
    check("R11 load scan on empty table", 64'(c), 64'(DEPTH));
    put('0, '0, '0, '0); run(4'd6, 1'b0, 4'd0, c);
    rd(2'd0, v); check("R8 next word0", 64'(v), 64'h2233_4455);
    rd(2'd1, v); check("R8 next word1", 64'(v), 64'h0003_0011);
    rd(2'd2, v); check("R8 next word2", 64'(v), 64'h0000_500F);
    put(MB, 7'h10, 4'h7, 12'h007); run(4'd2, 1'b0, 4'd0, c);
    put(MA, 7'h01, 4'h1, 12'h009); run(4'd2, 1'b0, 4'd0, c);
    walk(1'b0, 4'd0);
    check("R4 three entries", 64'(got_n), 64'd3);
    check("R4 slot0", 64'(got_mac[0]), 64'(MA));
    check("R4 slot1", 64'(got_mac[1]), 64'(MB));
    check("R4 slot2 same mac new vlan", 64'(got_mac[2]), 64'(MA));
  endtask

  task automatic t_overwrite;
    logic [31:0] v;
    int c;
    put(MA, 7'h40, 4'h7, 12'h005); run(4'd2, 1'b0, 4'd0, c);
    check("R11 in-place load at slot0 one cycle", 64'(c), 64'd1);
    walk(1'b0, 4'd0);
    check("R4 overwrite keeps count", 64'(got_n), 64'd3);
    put('0, '0, '0, '0); run(4'd6, 1'b0, 4'd0, c);
    rd(2'd1, v); check("R4 overwritten port mask", 64'(v), 64'h0040_0011);
    rd(2'd2, v); check("R4 overwritten status", 64'(v), 64'h0000_5007);
  endtask

  task automatic t_filter;
    walk(1'b1, 4'd4);
    check("R9 port4 count", 64'(got_n), 64'd1);
    check("R9 port4 entry", 64'(got_mac[0]), 64'(MB));
    walk(1'b1, 4'd0);
    check("R9 port0 count", 64'(got_n), 64'd1);
    walk(1'b1, 4'd7);
    check("R9 port7 none", 64'(got_n), 64'd0);
  endtask

  task automatic t_full;
    logic [31:0] v;
    int c;
    put(MD, 7'h7F, 4'h2, 12'hFFF); run(4'd2, 1'b0, 4'd0, c);
    rd(2'd3, v); check("R5 no full when slot free", 64'(v[12]), 64'd0);
    put(ME, 7'h01, 4'h3, 12'h001); run(4'd2, 1'b0, 4'd0, c);
    rd(2'd3, v); check("R5 full flag set", 64'(v[12]), 64'd1);
    walk(1'b0, 4'd0);
    check("R5 table unchanged when full", 64'(got_n), 64'd4);
    check("R5 last slot kept", 64'(got_mac[3]), 64'(MD));
    rd(2'd3, v); check("R5 full cleared by next command", 64'(v[12]), 64'd0);
  endtask

  task automatic t_purge;
    int c;
    put(MB, 7'h00, 4'h1, 12'h007); run(4'd3, 1'b0, 4'd0, c);
    walk(1'b0, 4'd0);
    check("R6 purge removes one", 64'(got_n), 64'd3);
    check("R6 next after gap", 64'(got_mac[1]), 64'(MA));
    put(MB, 7'h00, 4'h1, 12'h007); run(4'd3, 1'b0, 4'd0, c);
    walk(1'b0, 4'd0);
    check("R6 purge miss no change", 64'(got_n), 64'd3);
    put(MF, 7'h20, 4'h4, 12'h002); run(4'd2, 1'b0, 4'd0, c);
    walk(1'b0, 4'd0);
    check("R4 lowest free slot reused", 64'(got_mac[1]), 64'(MF));
  endtask

  task automatic t_busy;
    logic [31:0] v;
    int c;
    wr(2'd0, 32'h1111_1111);
    wr(2'd3, 32'h8000_0001);
    wr(2'd0, 32'hDEAD_BEEF);
    wr(2'd3, 32'h8000_0006);
    repeat (DEPTH) @(negedge clk);
    rd(2'd0, v); check("R10 data write ignored while busy", 64'(v), 64'h1111_1111);
    rd(2'd3, v); check("R10 function write ignored while busy", 64'(v), 64'h0000_0001);
    walk(1'b0, 4'd0);
    check("R7 flush empties table", 64'(got_n), 64'd0);
    put(MA, 7'h01, 4'h1, 12'h001); run(4'd2, 1'b0, 4'd0, c);
    run(4'd1, 1'b0, 4'd0, c);
    check("R7 flush latency", 64'(c), 64'(DEPTH));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_empty_next();
    t_load();
    t_overwrite();
    t_filter();
    t_full();
    t_purge();
    t_busy();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule